// File: doc/BRIEF.md
# Panel Line and Frame Timing Generator

This block produces the four timing strobes that a raster display panel needs: a pixel clock, a line clock, a frame clock and an output enable. It divides the system clock down to a pixel period, counts pixel periods across each line and lines across each frame, and pulses the frame clock once the programmed number of lines has been scanned. Line and pixel counts are programmed as the value minus one, so a 10-bit field covers 1 to 1024.

The configuration inputs are treated as static register values. They are captured only at the start of a frame, so a value written mid-frame takes effect on the following frame. Three polarity selects set the active level of the pixel clock edge, the line clock and the output enable. An active/passive select decides whether the output enable is used at all. A dual-panel select makes the block also report the row being scanned in the lower half panel, which is scanned in parallel with the upper half.

The scan sequencer has four states. ST_IDLE is entered on reset and lasts one system clock, and the configuration is captured as it leaves. ST_PIXEL covers the visible pixel periods of a line, and it moves to ST_LSYNC after the last pixel. ST_LSYNC holds the line clock for one pixel period, then moves back to ST_PIXEL, or to ST_FSYNC after the last line. ST_FSYNC holds the frame clock for one pixel period, captures the configuration again and moves to ST_PIXEL. Every state other than ST_IDLE advances only at the end of a pixel period.

Top module: `panel_timing_gen`

## Requirements
- R1: While reset is held, and with all selects low, the pixel clock, line clock, frame clock, output enable, row and lower-row outputs are all 0.
- R2: The pixel period P is 2*(divisor+1) system clocks when double rate is off. When double rate is on, P is divisor+1, or 2 when the divisor is 0. Within each period the un-inverted pixel clock is low for floor(P/2) clocks and then high for the rest, so data changes on its falling edge.
- R3: Each line is (pixels_m1+1) pixel periods of visible data, followed by exactly one pixel period with the line clock active.
- R4: After lines_m1+1 line clocks, the frame clock is active for exactly one pixel period. The frame therefore spans ((lines_m1+1)*(pixels_m1+2)+1)*P system clocks.
- R5: In active mode, the output enable is at its active level for exactly the visible pixel periods: (lines_m1+1)*(pixels_m1+1)*P system clocks per frame.
- R6: In passive mode, the output enable stays 0 whatever the enable polarity select is.
- R7: Polarity selects: oe_inv_i=1 makes the enable active low, lclk_inv_i=1 makes the line clock active low, and pclk_inv_i=1 inverts the pixel clock so that data is presented for falling-edge sampling. With a select at 0, its signal is active high.
- R8: With dual_i=1, row_lo_vld_o is 1 and row_lo_o equals row_o+lines_m1+1, and the line count per frame does not change. With dual_i=0, both lower-row outputs are 0.
- R9: All configuration inputs are captured only at frame start. A change made mid-frame leaves the current frame's timing unchanged and applies from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| lines_m1_i | input | LPP_W | Lines per panel minus one |
| pix_m1_i | input | PPL_W | Visible pixels per line minus one |
| pdiv_i | input | DIV_W | Pixel clock divisor |
| dbl_rate_i | input | 1 | Double-rate pixel clock select |
| dual_i | input | 1 | Dual-panel select |
| active_i | input | 1 | 1 = active display, 0 = passive |
| oe_inv_i | input | 1 | Output enable active low |
| pclk_inv_i | input | 1 | Pixel clock inverted |
| lclk_inv_i | input | 1 | Line clock active low |
| pclk_o | output | 1 | Pixel clock |
| lclk_o | output | 1 | Line clock |
| fclk_o | output | 1 | Frame clock (active high) |
| oe_o | output | 1 | Output enable |
| row_o | output | LPP_W | Row being scanned (upper panel) |
| row_lo_o | output | LPP_W+1 | Row being scanned in the lower panel |
| row_lo_vld_o | output | 1 | Lower-row output valid (dual mode) |

## Verification
The main function is swept over every combination of 1 to 4 lines, 1 to 3 pixels, divisors 0 to 2 and both rates, alternating single and dual panel. This separates errors in the line and pixel count terms from errors in the divisor and double-rate terms, and it covers the clamped double-rate case at divisor 0. All eight polarity combinations are then run with an odd pixel period, so that an inverted pixel clock shows in its high time and not only in its edge count. Passive mode is run with the enable inverted, to confirm that the inversion is ignored. A pixel count changed in the middle of a frame tells frame-start capture apart from direct use of the inputs.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PIXEL = 2'd1,
        ST_LSYNC = 2'd2,
        ST_FSYNC = 2'd3
    } scan_st_e;

endpackage

// File: rtl/ptg_pclk_div.sv
module ptg_pclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             dbl_i,
    output logic             tick_o,
    output logic             raw_o
);
    localparam int CNT_W = DIV_W + 2;

    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        if (dbl_i) begin
            if (div_i == '0) per = CNT_W'(2);
            else             per = CNT_W'(div_i) + CNT_W'(1);
        end else begin
            per = (CNT_W'(div_i) + CNT_W'(1)) << 1;
        end
    end

    assign tick_o = run_i && (cnt_q == per - CNT_W'(1));
    assign raw_o  = (cnt_q >= (per >> 1));

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) cnt_q <= '0;
        else if (tick_o)     cnt_q <= '0;
        else                 cnt_q <= cnt_q + CNT_W'(1);
    end

    // R2
    cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        run_i |-> (cnt_q < per));

    // R2
    idle_count_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/ptg_scan_fsm.sv
module ptg_scan_fsm
    import ptg_pkg::*;
#(
    parameter int LPP_W = 10,
    parameter int PPL_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic [LPP_W-1:0] lpp_i,
    input  logic [PPL_W-1:0] ppl_i,
    output scan_st_e         st_o,
    output logic [PPL_W-1:0] px_o,
    output logic [LPP_W-1:0] ln_o,
    output logic             fstart_o
);
    scan_st_e         st_q, st_d;
    logic [PPL_W-1:0] px_q;
    logic [LPP_W-1:0] ln_q;
    logic             last_px, last_ln;

    assign last_px = (px_q == ppl_i);
    assign last_ln = (ln_q == lpp_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= ST_IDLE;
        else       st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  st_d = ST_PIXEL;
            ST_PIXEL: if (tick_i && last_px) st_d = ST_LSYNC;
            ST_LSYNC: if (tick_i) st_d = last_ln ? ST_FSYNC : ST_PIXEL;
            ST_FSYNC: if (tick_i) st_d = ST_PIXEL;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            px_q <= '0;
            ln_q <= '0;
        end else if (tick_i) begin
            unique case (st_q)
                ST_PIXEL: px_q <= last_px ? '0 : px_q + PPL_W'(1);
                ST_LSYNC: if (!last_ln) ln_q <= ln_q + LPP_W'(1);
                ST_FSYNC: begin
                    px_q <= '0;
                    ln_q <= '0;
                end
                default: ;
            endcase
        end
    end

    assign st_o     = st_q;
    assign px_o     = px_q;
    assign ln_o     = ln_q;
    assign fstart_o = (st_q == ST_IDLE) || (st_q == ST_FSYNC && tick_i);

    // R3
    px_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q != ST_IDLE) |-> (px_q <= ppl_i));

    // R4
    ln_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q != ST_IDLE) |-> (ln_q <= lpp_i));

    // R4
    fsync_entry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_FSYNC && $past(st_q) != ST_FSYNC) |-> ($past(st_q) == ST_LSYNC));

    // R3
    state_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q != ST_IDLE && !tick_i) |=> $stable(st_q));

endmodule

// File: rtl/ptg_out_stage.sv
module ptg_out_stage
    import ptg_pkg::*;
#(
    parameter int LPP_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  scan_st_e         st_i,
    input  logic             raw_i,
    input  logic             act_i,
    input  logic             oe_inv_i,
    input  logic             pclk_inv_i,
    input  logic             lclk_inv_i,
    input  logic             dual_i,
    input  logic [LPP_W-1:0] ln_i,
    input  logic [LPP_W-1:0] lines_i,
    output logic             pclk_o,
    output logic             lclk_o,
    output logic             fclk_o,
    output logic             oe_o,
    output logic [LPP_W-1:0] row_o,
    output logic [LPP_W:0]   row_lo_o,
    output logic             row_lo_vld_o
);
    logic [LPP_W:0] lo_sum;

    assign lo_sum = {1'b0, ln_i} + {1'b0, lines_i} + (LPP_W+1)'(1);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pclk_o       <= 1'b0;
            lclk_o       <= 1'b0;
            fclk_o       <= 1'b0;
            oe_o         <= 1'b0;
            row_o        <= '0;
            row_lo_o     <= '0;
            row_lo_vld_o <= 1'b0;
        end else begin
            pclk_o       <= raw_i ^ pclk_inv_i;
            lclk_o       <= (st_i == ST_LSYNC) ^ lclk_inv_i;
            fclk_o       <= (st_i == ST_FSYNC);
            oe_o         <= act_i ? ((st_i == ST_PIXEL) ^ oe_inv_i) : 1'b0;
            row_o        <= ln_i;
            row_lo_o     <= dual_i ? lo_sum : '0;
            row_lo_vld_o <= dual_i;
        end
    end

    // R6
    passive_oe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !act_i |=> !oe_o);

    // R8
    row_lo_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        row_lo_vld_o |-> (row_lo_o > {1'b0, row_o}));

    // R4
    fclk_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(fclk_o) |-> !lclk_inv_i || lclk_o);

endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
    import ptg_pkg::*;
#(
    parameter int LPP_W = 10,
    parameter int PPL_W = 10,
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [LPP_W-1:0] lines_m1_i,
    input  logic [PPL_W-1:0] pix_m1_i,
    input  logic [DIV_W-1:0] pdiv_i,
    input  logic             dbl_rate_i,
    input  logic             dual_i,
    input  logic             active_i,
    input  logic             oe_inv_i,
    input  logic             pclk_inv_i,
    input  logic             lclk_inv_i,
    output logic             pclk_o,
    output logic             lclk_o,
    output logic             fclk_o,
    output logic             oe_o,
    output logic [LPP_W-1:0] row_o,
    output logic [LPP_W:0]   row_lo_o,
    output logic             row_lo_vld_o
);
    logic [LPP_W-1:0] lpp_q;
    logic [PPL_W-1:0] ppl_q;
    logic [DIV_W-1:0] div_q;
    logic             dbl_q, dual_q, act_q, oe_inv_q, pclk_inv_q, lclk_inv_q;

    scan_st_e         st;
    logic [PPL_W-1:0] px;
    logic [LPP_W-1:0] ln;
    logic             fstart, tick, raw;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lpp_q      <= '0;
            ppl_q      <= '0;
            div_q      <= '0;
            dbl_q      <= 1'b0;
            dual_q     <= 1'b0;
            act_q      <= 1'b0;
            oe_inv_q   <= 1'b0;
            pclk_inv_q <= 1'b0;
            lclk_inv_q <= 1'b0;
        end else if (fstart) begin
            lpp_q      <= lines_m1_i;
            ppl_q      <= pix_m1_i;
            div_q      <= pdiv_i;
            dbl_q      <= dbl_rate_i;
            dual_q     <= dual_i;
            act_q      <= active_i;
            oe_inv_q   <= oe_inv_i;
            pclk_inv_q <= pclk_inv_i;
            lclk_inv_q <= lclk_inv_i;
        end
    end

    ptg_pclk_div #(.DIV_W(DIV_W)) div_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .run_i  (st != ST_IDLE),
        .div_i  (div_q),
        .dbl_i  (dbl_q),
        .tick_o (tick),
        .raw_o  (raw)
    );

    ptg_scan_fsm #(.LPP_W(LPP_W), .PPL_W(PPL_W)) fsm_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .tick_i   (tick),
        .lpp_i    (lpp_q),
        .ppl_i    (ppl_q),
        .st_o     (st),
        .px_o     (px),
        .ln_o     (ln),
        .fstart_o (fstart)
    );

    ptg_out_stage #(.LPP_W(LPP_W)) out_i (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .st_i         (st),
        .raw_i        (raw),
        .act_i        (act_q),
        .oe_inv_i     (oe_inv_q),
        .pclk_inv_i   (pclk_inv_q),
        .lclk_inv_i   (lclk_inv_q),
        .dual_i       (dual_q),
        .ln_i         (ln),
        .lines_i      (lpp_q),
        .pclk_o       (pclk_o),
        .lclk_o       (lclk_o),
        .fclk_o       (fclk_o),
        .oe_o         (oe_o),
        .row_o        (row_o),
        .row_lo_o     (row_lo_o),
        .row_lo_vld_o (row_lo_vld_o)
    );

    // R9
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st != ST_IDLE && !fstart) |=> ($stable(lpp_q) && $stable(ppl_q) && $stable(div_q)));

    // R9
    px_unused_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st == ST_FSYNC) |-> (px == '0));

endmodule

// File: tb/panel_timing_gen_tb.sv
`timescale 1ns/1ps
module panel_timing_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] lines_m1 = '0;
    logic [9:0] pix_m1 = '0;
    logic [7:0] pdiv = '0;
    logic       dbl = 0, dual = 0, act = 0, oe_inv = 0, pclk_inv = 0, lclk_inv = 0;
    logic       pclk_o, lclk_o, fclk_o, oe_o, row_lo_vld_o;
    logic [9:0] row_o;
    logic [10:0] row_lo_o;

    always #10 clk = ~clk;

    panel_timing_gen dut_i (
        .clk_i(clk), .rst_i(rst), .lines_m1_i(lines_m1), .pix_m1_i(pix_m1),
        .pdiv_i(pdiv), .dbl_rate_i(dbl), .dual_i(dual), .active_i(act),
        .oe_inv_i(oe_inv), .pclk_inv_i(pclk_inv), .lclk_inv_i(lclk_inv),
        .pclk_o(pclk_o), .lclk_o(lclk_o), .fclk_o(fclk_o), .oe_o(oe_o),
        .row_o(row_o), .row_lo_o(row_lo_o), .row_lo_vld_o(row_lo_vld_o)
    );

    int checks = 0, errors = 0;
    int c_lpp, c_ppl, c_div, c_dbl, c_dual, c_act, c_oep, c_pcp, c_hsp;
    int cyc, lcl, oen, pr, ph, fh, bad_oe, bad_row;
    bit prev_pa;

    task automatic chk(bit ok, string req, int actual, int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic set_cfg(int l, int p, int d, int db, int du, int a, int oep, int pcp, int hsp);
        lines_m1 = 10'(l); pix_m1 = 10'(p); pdiv = 8'(d); dbl = db[0]; dual = du[0];
        act = a[0]; oe_inv = oep[0]; pclk_inv = pcp[0]; lclk_inv = hsp[0];
        c_lpp = l; c_ppl = p; c_div = d; c_dbl = db; c_dual = du; c_act = a;
        c_oep = oep; c_pcp = pcp; c_hsp = hsp;
    endtask

    task automatic sample_stats();
        bit pa;
        cyc++;
        if (lclk_o ^ c_hsp[0]) lcl++;
        if (c_act != 0) begin
            if (oe_o ^ c_oep[0]) oen++;
        end else if (oe_o) bad_oe++;
        pa = pclk_o ^ c_pcp[0];
        if (pa) ph++;
        if (pa && !prev_pa) pr++;
        prev_pa = pa;
        if (fclk_o) fh++;
        if (c_dual != 0) begin
            if (!row_lo_vld_o || int'(row_lo_o) != int'(row_o) + c_lpp + 1) bad_row++;
        end else if (row_lo_vld_o || row_lo_o != '0) bad_row++;
    endtask

    task automatic wait_fall();
        bit pf;
        pf = fclk_o;
        forever begin
            @(negedge clk);
            if (pf && !fclk_o) break;
            pf = fclk_o;
        end
    endtask

    // Called right after a frame-clock fall; measures up to the next fall.
    task automatic measure(int chg_at, int new_ppl);
        bit pf;
        cyc = 0; lcl = 0; oen = 0; pr = 0; ph = 0; fh = 0; bad_oe = 0; bad_row = 0;
        prev_pa = 1'b1;
        sample_stats();
        pf = fclk_o;
        forever begin
            @(negedge clk);
            if (cyc == chg_at) pix_m1 = 10'(new_ppl);
            if (pf && !fclk_o) break;
            pf = fclk_o;
            sample_stats();
        end
    endtask

    task automatic check_frame(string tag);
        int per, n;
        if (c_dbl != 0) per = (c_div == 0) ? 2 : c_div + 1;
        else            per = 2 * (c_div + 1);
        n = (c_lpp + 1) * (c_ppl + 2) + 1;
        chk(cyc == n * per, {"R4 frame length", tag}, cyc, n * per);
        chk(lcl == (c_lpp + 1) * per, {"R3 line clock time", tag}, lcl, (c_lpp + 1) * per);
        chk(fh == per, {"R4 frame clock width", tag}, fh, per);
        chk(pr == n, {"R2 pixel periods", tag}, pr, n);
        chk(ph == n * (per - per / 2), {"R2 pixel high time", tag}, ph, n * (per - per / 2));
        if (c_act != 0)
            chk(oen == (c_lpp + 1) * (c_ppl + 1) * per, {"R5 enable time", tag}, oen,
                (c_lpp + 1) * (c_ppl + 1) * per);
        else
            chk(bad_oe == 0, {"R6 passive enable", tag}, bad_oe, 0);
        chk(bad_row == 0, {"R8 lower row", tag}, bad_row, 0);
    endtask

    task automatic run_cfg(string tag);
        wait_fall();
        wait_fall();
        measure(-1, 0);
        check_frame(tag);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        set_cfg(0, 0, 0, 0, 0, 1, 0, 0, 0);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!pclk_o && !lclk_o && !fclk_o && !oe_o, "R1 strobes in reset",
            {pclk_o, lclk_o, fclk_o, oe_o}, 0);
        chk(row_o == '0 && row_lo_o == '0 && !row_lo_vld_o, "R1 rows in reset", int'(row_lo_o), 0);
        rst = 1'b0;

        // Sweep of the main function (R2 R3 R4 R5 R8)
        for (int l = 0; l < 4; l++)
            for (int p = 0; p < 3; p++)
                for (int d = 0; d < 3; d++)
                    for (int b = 0; b < 2; b++) begin
                        set_cfg(l, p, d, b, (l + p) % 2, 1, 0, 0, 0);
                        run_cfg("");
                    end

        // R7 polarity combinations, odd pixel period
        for (int m = 0; m < 8; m++) begin
            set_cfg(2, 1, 2, 1, 0, 1, m & 1, (m >> 1) & 1, (m >> 2) & 1);
            run_cfg(" (R7)");
        end

        // R6 passive mode ignores the enable polarity
        set_cfg(1, 2, 0, 0, 1, 0, 1, 0, 0);
        run_cfg(" (R6 inverted)");
        set_cfg(3, 0, 1, 1, 0, 0, 0, 1, 1);
        run_cfg(" (R6 plain)");

        // R9 mid-frame change applies from the next frame only
        set_cfg(2, 1, 1, 0, 0, 1, 0, 0, 0);
        wait_fall();
        wait_fall();
        measure(5, 3);
        check_frame(" (R9 current frame)");
        c_ppl = 3;
        measure(-1, 0);
        check_frame(" (R9 next frame)");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule